// File: doc/BRIEF.md
# Shadow RAM Region Controller

This block is a small chipset control unit on an 8-bit I/O port bus. It keeps three byte-wide configuration registers, one of which steers memory cycles in the upper-memory area (0xC0000 to 0xFFFFF). For every memory address and direction presented, it decides combinationally whether the cycle is served by on-board shadow DRAM or passed to the external ROM/ISA path. It also drives a cache-enable flag.

The routing register divides the area into five windows. Four windows are 32 KiB each, from 0xC0000 to 0xDFFFF. The fifth is a single 128 KiB window from 0xE0000 to 0xFFFFF. Each window has its own enable bit. One shared mode bit decides, for every enabled window at once, which direction goes to shadow RAM. Two status outputs report whether the system BIOS is shadowed and whether it is write-shadowed.

Top module: `shadow_region_ctl`

## Requirements
- R1: Writing a byte to I/O address 0x23, 0x25 or 0x27 stores it. A later read of that address on `io_rdata` returns the same byte.
- R2: Reading any other I/O address returns 0xFF. Writing any other I/O address changes none of the three registers.
- R3: After reset all three registers read 0x00. Every memory cycle then routes external, with `mem_ken`, `bios_shadowed` and `bios_wshadow` low.
- R4: Bits 0, 1, 2 and 3 of register 0x25 enable the 32 KiB windows at 0xC0000, 0xC8000, 0xD0000 and 0xD8000, in that order.
- R5: Bit 4 of register 0x25 enables the 128 KiB window at 0xE0000–0xFFFFF.
- R6: In an enabled window with bit 5 clear, reads (`mem_we`=0) go to shadow (`mem_shadow`=1) and writes go external. With bit 5 set, writes go to shadow and reads go external.
- R7: In a window whose enable bit is clear, both directions route external (`mem_shadow`=0), whatever bit 5 holds.
- R8: `mem_ken` is high exactly when bit 6 of register 0x25 is set and the address lies in an enabled window. The direction of the cycle does not matter.
- R9: `bios_shadowed` equals bit 4 of register 0x25. `bios_wshadow` is high only when bits 4 and 5 are both set.
- R10: Addresses below 0xC0000 always route external, with `mem_ken` low.
- R11: A register write takes effect on routing and read-back from the clock edge that accepts it. Before that edge the old value is still in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe, sampled at the clock edge |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for `io_addr` (combinational) |
| mem_addr | input | 20 | Memory cycle address |
| mem_we | input | 1 | 1 = memory write, 0 = memory read |
| mem_shadow | output | 1 | 1 = cycle served by shadow DRAM, 0 = external path |
| mem_ken | output | 1 | Cache enable for the current cycle |
| bios_shadowed | output | 1 | System BIOS window is shadowed |
| bios_wshadow | output | 1 | System BIOS is write-shadowed |

## Verification
The bench probes both edges of each window: the last byte of one 32 KiB window against the first byte of the next, and 0xBFFFF against 0xC0000. A decoder that compares too few address bits would route across those boundaries. It turns the mode bit on and off with the same enables in place, which exposes a reversed or missing direction swap. It also checks that a disabled window ignores the mode bit and that `mem_ken` stays low outside enabled windows. Other cases cover unmapped I/O reads, including addresses that alias one of the three ports in the low byte, writes to unmapped ports, and the cycle in which a new value first becomes visible.

// File: rtl/shadow_region_ctl.sv
module shadow_region_ctl #(
  parameter int IO_AW = 16,
  parameter int MEM_AW = 20,
  parameter logic [IO_AW-1:0] PORT_A = 16'h0023,
  parameter logic [IO_AW-1:0] PORT_MAP = 16'h0025,
  parameter logic [IO_AW-1:0] PORT_C = 16'h0027
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_we,
  output logic              mem_shadow,
  output logic              mem_ken,
  output logic              bios_shadowed,
  output logic              bios_wshadow
);
  localparam int WIN = 5;

  logic [7:0] reg_a, reg_map, reg_c;
  logic [WIN-1:0] hit;
  logic en_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a   <= 8'h00;
      reg_map <= 8'h00;
      reg_c   <= 8'h00;
    end else if (io_wr) begin
      if (io_addr == PORT_A)   reg_a   <= io_wdata;
      if (io_addr == PORT_MAP) reg_map <= io_wdata;
      if (io_addr == PORT_C)   reg_c   <= io_wdata;
    end
  end

  always_comb begin
    if (io_addr == PORT_A)        io_rdata = reg_a;
    else if (io_addr == PORT_MAP) io_rdata = reg_map;
    else if (io_addr == PORT_C)   io_rdata = reg_c;
    else                          io_rdata = 8'hFF;
  end

  genvar i;
  generate
    for (i = 0; i < 4; i++) begin : g_small
      assign hit[i] = (mem_addr[MEM_AW-1:MEM_AW-5] == (5'b11000 | 5'(i)));
    end
  endgenerate
  assign hit[4] = (mem_addr[MEM_AW-1:MEM_AW-3] == 3'b111);

  assign en_hit        = |(hit & reg_map[WIN-1:0]);
  assign mem_shadow    = en_hit & (mem_we == reg_map[5]);
  assign mem_ken       = en_hit & reg_map[6];
  assign bios_shadowed = reg_map[4];
  assign bios_wshadow  = reg_map[4] & reg_map[5];
endmodule

// File: rtl/shadow_region_ctl_chk.sv
module shadow_region_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic        io_wr,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata,
  input logic [19:0] mem_addr,
  input logic        mem_we,
  input logic        mem_shadow,
  input logic        mem_ken,
  input logic        bios_shadowed,
  input logic        bios_wshadow,
  input logic [7:0]  reg_map
);
  // R11
  map_write_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 16'h0025) |=> (reg_map == $past(io_wdata)));
  // R2
  unmapped_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr != 16'h0023 && io_addr != 16'h0025 && io_addr != 16'h0027) |-> (io_rdata == 8'hFF));
  // R10
  low_mem_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[19:18] != 2'b11) |-> (!mem_shadow && !mem_ken));
  // R6
  shadow_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_shadow |-> (mem_we == reg_map[5]));
  // R8
  ken_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ken |-> reg_map[6]);
  // R9
  bios_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bios_wshadow |-> bios_shadowed);
endmodule

bind shadow_region_ctl shadow_region_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
  .io_rdata(io_rdata), .mem_addr(mem_addr), .mem_we(mem_we), .mem_shadow(mem_shadow),
  .mem_ken(mem_ken), .bios_shadowed(bios_shadowed), .bios_wshadow(bios_wshadow),
  .reg_map(reg_map)
);

// File: tb/sim_shadow_region_ctl.sv
module sim_shadow_region_ctl;
  logic clk = 0, rst_n = 0, io_wr = 0, mem_we = 0;
  logic [15:0] io_addr = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic [19:0] mem_addr = 0;
  logic mem_shadow, mem_ken, bios_shadowed, bios_wshadow;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  shadow_region_ctl u0 (.*);

  // {cfg, we, addr, exp_shadow, exp_ken}
  localparam int NV = 16;
  localparam logic [30:0] VEC [NV] = '{
    {8'h01, 1'b0, 20'hC0000, 1'b1, 1'b0},
    {8'h01, 1'b1, 20'hC7FFF, 1'b0, 1'b0},
    {8'h01, 1'b0, 20'hC8000, 1'b0, 1'b0},
    {8'h21, 1'b0, 20'hC4000, 1'b0, 1'b0},
    {8'h21, 1'b1, 20'hC4000, 1'b1, 1'b0},
    {8'h02, 1'b0, 20'hCFFFF, 1'b1, 1'b0},
    {8'h44, 1'b0, 20'hD0000, 1'b1, 1'b1},
    {8'h48, 1'b0, 20'hDFFFF, 1'b1, 1'b1},
    {8'h50, 1'b0, 20'hF0000, 1'b1, 1'b1},
    {8'h70, 1'b0, 20'hFFFFF, 1'b0, 1'b1},
    {8'h70, 1'b1, 20'hE0000, 1'b1, 1'b1},
    {8'h7F, 1'b0, 20'hBFFFF, 1'b0, 1'b0},
    {8'h7F, 1'b1, 20'hA0000, 1'b0, 1'b0},
    {8'h40, 1'b0, 20'hC0000, 1'b0, 1'b0},
    {8'h1F, 1'b1, 20'hD8000, 1'b0, 1'b0},
    {8'h2F, 1'b0, 20'hE0000, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(posedge clk); #1;
    io_wr = 0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; #1;
    d = io_rdata;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R3 reset state
    io_read(16'h0023, rd); chk("R3 reg23", rd, 8'h00);
    io_read(16'h0025, rd); chk("R3 reg25", rd, 8'h00);
    io_read(16'h0027, rd); chk("R3 reg27", rd, 8'h00);
    mem_addr = 20'hF0000; mem_we = 0; #1;
    chk("R3 route", {mem_shadow, mem_ken, bios_shadowed, bios_wshadow}, 4'b0000);

    // R4 R5 R6 R7 R8 R10 vector table
    for (int i = 0; i < NV; i++) begin
      io_write(16'h0025, VEC[i][30:23]);
      @(negedge clk);
      mem_we = VEC[i][22]; mem_addr = VEC[i][21:2]; #1;
      chk($sformatf("R4/R5/R6/R7/R10 route v%0d", i), mem_shadow, VEC[i][1]);
      chk($sformatf("R8 ken v%0d", i), mem_ken, VEC[i][0]);
    end

    // R1 read-back
    io_write(16'h0023, 8'hA5); io_write(16'h0027, 8'h3C); io_write(16'h0025, 8'h5A);
    io_read(16'h0023, rd); chk("R1 reg23", rd, 8'hA5);
    io_read(16'h0025, rd); chk("R1 reg25", rd, 8'h5A);
    io_read(16'h0027, rd); chk("R1 reg27", rd, 8'h3C);

    // R2 unmapped reads and writes
    io_read(16'h0024, rd); chk("R2 read 24", rd, 8'hFF);
    io_read(16'h0123, rd); chk("R2 read 123", rd, 8'hFF);
    io_read(16'h0000, rd); chk("R2 read 0", rd, 8'hFF);
    io_write(16'h0125, 8'h00); io_write(16'h0024, 8'h00);
    io_read(16'h0025, rd); chk("R2 no alias write", rd, 8'h5A);
    io_read(16'h0023, rd); chk("R2 reg23 kept", rd, 8'hA5);

    // R9 BIOS flags
    io_write(16'h0025, 8'h10); #1;
    chk("R9 bios ro", {bios_shadowed, bios_wshadow}, 2'b10);
    io_write(16'h0025, 8'h30); #1;
    chk("R9 bios rw", {bios_shadowed, bios_wshadow}, 2'b11);
    io_write(16'h0025, 8'h20); #1;
    chk("R9 bios off", {bios_shadowed, bios_wshadow}, 2'b00);

    // R11 timing: old value before the edge, new value after
    io_write(16'h0025, 8'h00);
    @(negedge clk);
    mem_addr = 20'hC0000; mem_we = 0;
    io_addr = 16'h0025; io_wdata = 8'h01; io_wr = 1; #1;
    chk("R11 before edge", mem_shadow, 1'b0);
    @(posedge clk); #1; io_wr = 0;
    chk("R11 after edge", mem_shadow, 1'b1);

    // R3 reset clears again
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1; rst_n = 1;
    io_read(16'h0025, rd); chk("R3 re-reset", rd, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule